// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is the target-side front end of a two-wire serial bus (I2C) wrapped around a 256-byte memory. The system clock oversamples the bus clock and data lines through a short synchronizer. The block detects START and STOP conditions and decodes the first byte of each transfer against a fixed 7-bit device address. It answers on the data line through an open-drain enable, where a 1 pulls the wire low.

A write transfer loads an 8-bit word pointer and then takes one data byte. The STOP that follows starts a self-timed programming interval. While that interval runs, the block stays off the bus entirely and stores the byte only when the interval ends. A read transfer streams bytes from the pointer for as long as the controller acknowledges each one. A repeated START after the pointer byte gives a random-address read.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the data-line enable is released (0), every memory byte reads as 0x00 and the word pointer is 0.
- R2: A first byte of 1010000 followed by the direction bit (MSB first; 0 = write, 1 = read) is acknowledged by pulling the data line low during the ninth bus clock.
- R3: A first byte with any other 7-bit address gets no acknowledge, and the enable stays released for every following byte until the next START.
- R4: A write transfer is acknowledged on the device byte, on the word-pointer byte and on the data byte. After the STOP and the programming interval, the data byte is stored at the pointer location.
- R5: The programming interval lasts PROG_CYCLES system clocks from the STOP. During it no byte, not even a matching address, is acknowledged. After it, the block responds again.
- R6: In read mode the byte at the pointer is sent MSB first. The enable changes only while the synchronized bus clock is low.
- R7: After each byte sent, the pointer advances by one and wraps from 255 to 0. When the controller acknowledges, the next byte follows at once.
- R8: When the controller does not acknowledge a read byte, the enable stays released until the next START or STOP.
- R9: Storing a write data byte leaves the pointer one past the written location, so a following read with no pointer byte returns the next location.
- R10: A repeated START after the pointer byte begins a new transfer without a STOP, so a read can follow from the loaded pointer.
- R11: A STOP that ends a write transfer before any data byte starts no programming interval, and the block answers at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Data line as seen on the wire |
| sda_oe | output | 1 | Data-line pull-down enable, 1 drives the wire low |

## Verification
The hardest case to reach from the ports is a request that lands inside the programming interval. The block's only sign of being busy is a missing acknowledge. The stimulus therefore issues a matching address immediately after the STOP of a write, well inside a bench-shortened interval, and expects silence. It then waits past the interval and expects an acknowledge again. The pointer wrap needs data at both ends of the array, so the bench writes locations 255 and 0 first and then reads across the boundary with a repeated START.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } slv_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] scl_pipe_q;
    logic [LAST:0] sda_pipe_q;
    logic          scl_prev_q;
    logic          sda_prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= scl_i;
                    sda_pipe_q <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= {scl_pipe_q[LAST-1:0], scl_i};
                    sda_pipe_q <= {sda_pipe_q[LAST-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_pipe_q[LAST];
            sda_prev_q <= sda_pipe_q[LAST];
        end
    end

    assign scl_s     = scl_pipe_q[LAST];
    assign sda_s     = sda_pipe_q[LAST];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_prog_timer.sv
module i2c_prog_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else if (start) begin
            cnt_d = CW'(CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b1010000,
    parameter int unsigned AW          = 8,
    parameter int unsigned PROG_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        slv_state_e        state;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [AW-1:0]     ptr;
        logic              oe;
        logic              pend;
        logic              mack;
        logic [AW-1:0]     wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } slv_regs_t;

    slv_regs_t st_d, st_q;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, prog_done, prog_start, mem_we;
    logic [BYTE_W-1:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy),
        .done  (prog_done)
    );

    assign mem_we = prog_done;

    i2c_byte_store #(.AW(AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (st_q.wr_addr),
        .wdata (st_q.wr_data),
        .raddr (st_q.ptr),
        .rdata (rd_data)
    );

    always_comb begin
        st_d       = st_q;
        prog_start = 1'b0;
        if (busy) begin
            st_d.state = ST_IDLE;
            st_d.oe    = 1'b0;
            st_d.pend  = 1'b0;
        end else if (stop_det) begin
            prog_start = st_q.pend;
            st_d.state = ST_IDLE;
            st_d.oe    = 1'b0;
            st_d.pend  = 1'b0;
        end else if (start_det) begin
            st_d.state  = ST_DEV;
            st_d.bitcnt = '0;
            st_d.oe     = 1'b0;
            st_d.pend   = 1'b0;
        end else begin
            unique case (st_q.state)
                ST_IDLE, ST_WAIT_STOP: begin
                    st_d.oe = 1'b0;
                end
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && st_q.bitcnt != CNT_W'(BYTE_W)) begin
                        st_d.shreg  = {st_q.shreg[BYTE_W-2:0], sda_s};
                        st_d.bitcnt = st_q.bitcnt + CNT_W'(1);
                    end else if (scl_fall && st_q.bitcnt == CNT_W'(BYTE_W)) begin
                        st_d.bitcnt = '0;
                        if (st_q.state == ST_DEV) begin
                            if (st_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                st_d.oe    = 1'b1;
                                st_d.state = ST_DEV_ACK;
                            end else begin
                                st_d.state = ST_IDLE;
                            end
                        end else if (st_q.state == ST_WADDR) begin
                            st_d.ptr   = st_q.shreg[AW-1:0];
                            st_d.oe    = 1'b1;
                            st_d.state = ST_WADDR_ACK;
                        end else begin
                            st_d.wr_addr = st_q.ptr;
                            st_d.wr_data = st_q.shreg;
                            st_d.ptr     = st_q.ptr + AW'(1);
                            st_d.pend    = 1'b1;
                            st_d.oe      = 1'b1;
                            st_d.state   = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        st_d.bitcnt = '0;
                        if (st_q.shreg[0]) begin
                            st_d.shreg = rd_data;
                            st_d.oe    = ~rd_data[BYTE_W-1];
                            st_d.state = ST_RD_BYTE;
                        end else begin
                            st_d.oe    = 1'b0;
                            st_d.state = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_fall) begin
                        st_d.oe     = 1'b0;
                        st_d.bitcnt = '0;
                        st_d.state  = ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        st_d.oe    = 1'b0;
                        st_d.state = ST_WAIT_STOP;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (st_q.bitcnt == CNT_W'(BYTE_W - 1)) begin
                            st_d.oe    = 1'b0;
                            st_d.ptr   = st_q.ptr + AW'(1);
                            st_d.mack  = 1'b0;
                            st_d.state = ST_RD_ACK;
                        end else begin
                            st_d.shreg  = {st_q.shreg[BYTE_W-2:0], 1'b0};
                            st_d.oe     = ~st_q.shreg[BYTE_W-2];
                            st_d.bitcnt = st_q.bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.shreg  = rd_data;
                            st_d.oe     = ~rd_data[BYTE_W-1];
                            st_d.bitcnt = '0;
                            st_d.state  = ST_RD_BYTE;
                        end else begin
                            st_d.state = ST_WAIT_STOP;
                        end
                    end
                end
                default: begin
                    st_d.state = ST_IDLE;
                    st_d.oe    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, bitcnt: '0, shreg: '0, ptr: '0, oe: 1'b0,
                      pend: 1'b0, mack: 1'b0, wr_addr: '0, wr_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe = st_q.oe;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          busy,
    input logic          stop_det,
    input logic          mem_we,
    input slv_state_e    state,
    input logic [AW-1:0] ptr
);

    // R6
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R5
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R4
    store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R8
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP) |-> !sda_oe);

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && $past(state) == ST_RD_BYTE) |-> ptr == AW'($past(ptr) + 1'b1));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .stop_det (stop_det),
    .mem_we   (mem_we),
    .state    (st_q.state),
    .ptr      (st_q.ptr)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;

    localparam int PROG = 600;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_mem_slave #(.PROG_CYCLES(PROG)) i_i2c_mem_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    typedef struct {
        string req;
        int    val;
    } exp_t;

    exp_t        exp_q[$];
    int          obs_q[$];
    int          tests = 0;
    int          fails = 0;
    int          r6_bad = 0;
    logic [7:0]  model [256];
    logic        prev_oe = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items as observed results arrive
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                exp_t e;
                int   o;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                check(e.req, o, e.val);
            end
        end
    end

    // R6: enable must not move while the bus clock is high
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sda_oe !== prev_oe && scl == 1'b1) r6_bad++;
            prev_oe = sda_oe;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_m = b[i];
            wq(); scl = 1'b1;
            wq(); wq(); scl = 1'b0;
        end
        wq(); sda_m = 1'b1;
        wq(); scl = 1'b1;
        wq(); acked = (sda_bus == 1'b0);
        wq(); scl = 1'b0;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_m = 1'b1;
            wq(); scl = 1'b1;
            wq(); b[i] = sda_bus;
            wq(); scl = 1'b0;
        end
        wq(); sda_m = ~give_ack;
        wq(); scl = 1'b1;
        wq(); wq(); scl = 1'b0;
    endtask

    // driver tasks: push the expectation, then run the transfer
    task automatic send_exp(input logic [7:0] b, input int exp_ack, input string req);
        logic a;
        exp_q.push_back('{req: req, val: exp_ack});
        put_byte(b, a);
        obs_q.push_back(int'(a));
    endtask

    task automatic read_exp(input logic give_ack, input logic [7:0] exp_b, input string req);
        logic [7:0] b;
        exp_q.push_back('{req: req, val: int'(exp_b)});
        get_byte(give_ack, b);
        obs_q.push_back(int'(b));
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bus_start();
        send_exp(8'hA0, 1, "R4 dev ack");
        send_exp(a, 1, "R4 ptr ack");
        send_exp(d, 1, "R4 data ack");
        bus_stop();
        model[a] = d;
    endtask

    task automatic wait_prog();
        repeat (PROG + 100) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        check("R1 oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 oe after reset", int'(sda_oe), 0);

        // R1, R2: current-address read straight after reset
        bus_start();
        send_exp(8'hA1, 1, "R2 read addr ack");
        read_exp(1'b0, 8'h00, "R1 reset data");
        bus_stop();

        // R3: foreign address, then a further byte
        bus_start();
        send_exp(8'hA2, 0, "R3 mismatch nak");
        send_exp(8'h00, 0, "R3 later byte nak");
        bus_stop();

        // R4, R5: write then probe inside the programming interval
        do_write(8'h10, 8'h5A);
        bus_start();
        send_exp(8'hA0, 0, "R5 busy nak");
        bus_stop();
        wait_prog();
        do_write(8'h11, 8'hC3);
        wait_prog();

        // R10, R7, R8: random read, sequential stream, controller NACK
        bus_start();
        send_exp(8'hA0, 1, "R10 dev ack");
        send_exp(8'h10, 1, "R10 ptr ack");
        bus_start();
        send_exp(8'hA1, 1, "R10 restart ack");
        read_exp(1'b1, 8'h5A, "R4 stored 0x10");
        read_exp(1'b1, 8'hC3, "R7 next byte");
        read_exp(1'b0, 8'h00, "R7 third byte");
        begin
            logic [7:0] b;
            exp_q.push_back('{req: "R8 released after nack", val: 8'hFF});
            get_byte(1'b0, b);
            obs_q.push_back(int'(b));
        end
        bus_stop();

        // R7: wrap from 255 to 0
        do_write(8'hFF, 8'hE1);
        wait_prog();
        do_write(8'h00, 8'h3C);
        wait_prog();
        bus_start();
        send_exp(8'hA0, 1, "R10 dev ack");
        send_exp(8'hFF, 1, "R10 ptr ack");
        bus_start();
        send_exp(8'hA1, 1, "R10 restart ack");
        read_exp(1'b1, 8'hE1, "R7 byte at 255");
        read_exp(1'b0, 8'h3C, "R7 wrap to 0");
        bus_stop();

        // R9: pointer left one past the stored byte
        do_write(8'h20, 8'h77);
        wait_prog();
        do_write(8'h1F, 8'h99);
        wait_prog();
        bus_start();
        send_exp(8'hA1, 1, "R9 read ack");
        read_exp(1'b0, 8'h77, "R9 next location");
        bus_stop();

        // R11: pointer-only write does not start programming
        bus_start();
        send_exp(8'hA0, 1, "R11 dev ack");
        send_exp(8'h40, 1, "R11 ptr ack");
        bus_stop();
        bus_start();
        send_exp(8'hA1, 1, "R11 answers at once");
        read_exp(1'b0, model[8'h40], "R11 read loaded ptr");
        bus_stop();

        repeat (20) @(negedge clk);
        check("R6 oe moved while clock high", r6_bad, 0);
        wait (obs_q.size() == 0);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule